// File: doc/BRIEF.md
# Row-Address Cache Command Encoder

This block sits on the controller side of a DRAM command path. It shrinks the 18-bit row address of each activate so that it fits a 16-bit address bus. For each bank it keeps a small cache of recently used upper row bits. Before it sends an activate, it looks up the upper 7 bits of the row in the cache of the target bank. On a hit, a single 16-bit beat carries a 5-bit location code and the 11 low row bits. On a miss, the first beat carries a reserved miss code with the low bits. A second beat then carries the full upper portion, and the cache records it. The device keeps an identical cache and follows every fill in step with this block.

Each bank cache has 16 sets and 2 ways. The second way of the last set is disabled, which leaves 31 usable locations. Their codes never collide with the miss code. The set is taken straight from the row, so each entry stores only 3 tag bits. The way chosen for a fill follows a fixed rule that the device can repeat.

Top module: `rac_encoder`

## Requirements
- R1: After reset, `beat_valid` and `busy` are low, `req_ready` is high, and every set of every bank is empty, so the first activate to any set misses.
- R2: An accepted request (`req_valid && req_ready` at a rising edge) produces a first beat on the next cycle with `beat_valid` high. `beat_data[10:0]` equals row bits [10:0] and `beat_data[15:11]` holds the code.
- R3: On a miss, the code is 5'b11111. In the cycle after the first beat, a second beat follows with `beat_data = {9'b0, row[17:11]}`. Between the two beats `busy` is high and `req_ready` is low.
- R4: On a hit, only one beat is sent. Its code is `{way, set}`, with the way in bit 15 and the set in bits 14:11. `busy` stays low.
- R5: The set is row bits [17:14]. The stored tag is row bits [13:11]. A row whose set matches but whose tag differs misses.
- R6: Every set except set 15 has a 1-bit fill pointer that starts at way 0 and toggles on each fill. Fills therefore alternate way 0, way 1, way 0, and each fill replaces the entry it lands on.
- R7: Set 15 always fills way 0. Only code 5'b01111 can report a hit in set 15.
- R8: Each bank has its own cache. A fill in one bank leaves the hits and misses of every other bank unchanged.
- R9: `beat_valid` is high only in the cycle after an accept or in the cycle after `busy`. Otherwise it is low.
- R10: A fill is visible to the next accepted request. Repeating a row that just missed gives a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Activate request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bank | input | BANK_W | Target bank of the activate |
| req_row | input | 18 | Target row address |
| beat_valid | output | 1 | `beat_data` carries a beat this cycle |
| beat_data | output | 16 | Address-bus beat: code in [15:11], payload in [10:0] |
| busy | output | 1 | Second beat of a miss is pending |

## Verification
The bench fills one set three times with alternating tags. A design whose fill pointer does not toggle, or does not start at way 0, then reports the wrong hit way or evicts the wrong entry. Set 15 gets two different tags. A design that lets way 1 of that set fill would produce a hit code equal to the miss code, or would keep the evicted tag alive. Rows that share a set but differ in tag, and identical rows sent to different banks, catch a design that skips the tag compare or shares storage between banks. After every miss the bench checks that `req_ready` goes low and that the second beat carries the upper bits. A dropped handshake or a wrong bit slice shows up there.

// File: rtl/rac_pkg.sv
package rac_pkg;
    localparam int ROW_W   = 18;
    localparam int LOW_W   = 11;
    localparam int CODE_W  = 5;
    localparam int SET_W   = 4;
    localparam int WAYS    = 2;
    localparam int MSP_W   = ROW_W - LOW_W;
    localparam int TAG_W   = MSP_W - SET_W;
    localparam int SETS    = 1 << SET_W;
    localparam int BEAT_W  = CODE_W + LOW_W;
    localparam logic [SET_W-1:0]  LAST_SET  = SET_W'(SETS - 1);
    localparam logic [CODE_W-1:0] MISS_CODE = '1;

    typedef struct packed {
        logic hit;
        logic way;
    } rac_look_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [LOW_W-1:0]  low;
    } rac_beat_t;

    function automatic logic [SET_W-1:0] row_set(input logic [ROW_W-1:0] row);
        return row[ROW_W-1 -: SET_W];
    endfunction

    function automatic logic [TAG_W-1:0] row_tag(input logic [ROW_W-1:0] row);
        return row[LOW_W +: TAG_W];
    endfunction

    function automatic logic [MSP_W-1:0] row_msp(input logic [ROW_W-1:0] row);
        return row[ROW_W-1 -: MSP_W];
    endfunction
endpackage

// File: rtl/rac_bank_cache.sv
module rac_bank_cache
    import rac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output rac_look_t        look,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [SETS-1:0][WAYS-1:0]             vld_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [SETS-1:0]                       ptr_q;

    logic hit0, hit1;
    logic fill_way;

    always_comb begin
        hit0 = vld_q[lk_set][0] && (tag_q[lk_set][0] == lk_tag);
        hit1 = vld_q[lk_set][1] && (tag_q[lk_set][1] == lk_tag)
               && (lk_set != LAST_SET);
        look.hit = hit0 || hit1;
        look.way = !hit0 && hit1;
    end

    assign fill_way = (wr_set == LAST_SET) ? 1'b0 : ptr_q[wr_set];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            tag_q <= '0;
            ptr_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_set][fill_way] <= 1'b1;
            tag_q[wr_set][fill_way] <= wr_tag;
            if (wr_set != LAST_SET)
                ptr_q[wr_set] <= !ptr_q[wr_set];
        end
    end
endmodule

// File: rtl/rac_beat_seq.sv
module rac_beat_seq
    import rac_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  rac_look_t         look,
    input  logic [ROW_W-1:0]  row,
    input  logic [BANK_W-1:0] bank,
    output logic              beat_valid,
    output rac_beat_t         beat,
    output logic              busy,
    output logic [BANK_W-1:0] pend_bank,
    output logic [MSP_W-1:0]  pend_msp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_valid <= 1'b0;
            busy       <= 1'b0;
            beat       <= '0;
            pend_bank  <= '0;
            pend_msp   <= '0;
        end else if (busy) begin
            beat_valid <= 1'b1;
            beat       <= rac_beat_t'({{(BEAT_W-MSP_W){1'b0}}, pend_msp});
            busy       <= 1'b0;
        end else if (acc) begin
            beat_valid <= 1'b1;
            beat.low   <= row[LOW_W-1:0];
            beat.code  <= look.hit ? {look.way, row_set(row)} : MISS_CODE;
            busy       <= !look.hit;
            pend_bank  <= bank;
            pend_msp   <= row_msp(row);
        end else begin
            beat_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/rac_encoder.sv
module rac_encoder
    import rac_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    output logic              beat_valid,
    output logic [BEAT_W-1:0] beat_data,
    output logic              busy
);
    rac_look_t         look [NUM_BANKS];
    rac_look_t         look_sel;
    rac_beat_t         beat;
    logic [BANK_W-1:0] pend_bank;
    logic [MSP_W-1:0]  pend_msp;
    logic              acc;

    assign req_ready = !busy;
    assign acc       = req_valid && req_ready;
    assign beat_data = beat;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rac_bank_cache u_cache (
            .clk    (clk),
            .rst    (rst),
            .lk_set (row_set(req_row)),
            .lk_tag (row_tag(req_row)),
            .look   (look[b]),
            .wr_en  (busy && (pend_bank == BANK_W'(b))),
            .wr_set (pend_msp[MSP_W-1 -: SET_W]),
            .wr_tag (pend_msp[TAG_W-1:0])
        );
    end

    always_comb begin
        look_sel = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (req_bank == BANK_W'(b))
                look_sel = look[b];
    end

    rac_beat_seq #(.BANK_W(BANK_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .look       (look_sel),
        .row        (req_row),
        .bank       (req_bank),
        .beat_valid (beat_valid),
        .beat       (beat),
        .busy       (busy),
        .pend_bank  (pend_bank),
        .pend_msp   (pend_msp)
    );
endmodule

// File: rtl/rac_encoder_chk.sv
module rac_encoder_chk
    import rac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LOW_W-1:0]  req_low,
    input logic              beat_valid,
    input logic [BEAT_W-1:0] beat_data,
    input logic              busy
);
    p_low_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> beat_valid && beat_data[LOW_W-1:0] == $past(req_low));

    p_miss_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_data[BEAT_W-1 -: CODE_W] == MISS_CODE) |-> busy && !req_ready);

    p_second_beat_r3: assert property (@(posedge clk) disable iff (rst)
        busy |=> beat_valid && !busy && beat_data[BEAT_W-1:MSP_W] == '0);

    p_hit_single_r4: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !$past(busy) && beat_data[BEAT_W-1 -: CODE_W] != MISS_CODE) |-> !busy);

    p_beat_source_r9: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> $past(req_valid && req_ready) || $past(busy));
endmodule

bind rac_encoder rac_encoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_low    (req_row[rac_pkg::LOW_W-1:0]),
    .beat_valid (beat_valid),
    .beat_data  (beat_data),
    .busy       (busy)
);

// File: tb/rac_encoder_tb.sv
module rac_encoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [17:0] req_row = '0;
    logic        beat_valid;
    logic [15:0] beat_data;
    logic        busy;

    int checks = 0;
    int errors = 0;

    always #10 clk = !clk;

    rac_encoder u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .beat_valid(beat_valid),
        .beat_data(beat_data), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] mk(input int set, input int tag, input int low);
        return {4'(set), 3'(tag), 11'(low)};
    endfunction

    // One activate; exp_hit/exp_way give the expected outcome.
    task automatic send(input string req, input int bank, input logic [17:0] row,
                        input bit exp_hit, input bit exp_way);
        @(negedge clk);
        chk({req, " R9 idle beat_valid"}, 32'(beat_valid), 0);
        chk({req, " R1 ready when idle"}, 32'(req_ready), 1);
        req_valid = 1'b1; req_bank = 2'(bank); req_row = row;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " R2 first beat valid"}, 32'(beat_valid), 1);
        chk({req, " R2 low bits"}, 32'(beat_data[10:0]), 32'(row[10:0]));
        if (exp_hit) begin
            chk({req, " R4 hit code"}, 32'(beat_data[15:11]), 32'({exp_way, row[17:14]}));
            chk({req, " R4 no busy on hit"}, 32'(busy), 0);
        end else begin
            chk({req, " R3 miss code"}, 32'(beat_data[15:11]), 32'h1f);
            chk({req, " R3 stall"}, 32'({busy, req_ready}), 32'b10);
            @(negedge clk);
            chk({req, " R3 second beat"}, 32'({beat_valid, beat_data}), 32'({1'b1, 9'b0, row[17:11]}));
            chk({req, " R3 busy cleared"}, 32'(busy), 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset beat_valid", 32'(beat_valid), 0);
        chk("R1 reset busy", 32'(busy), 0);
        chk("R1 reset ready", 32'(req_ready), 1);
    endtask

    task automatic t_cold_then_hit();
        send("R1 cold", 0, mk(3, 5, 11'h155), 0, 0);
        send("R10 repeat", 0, mk(3, 5, 11'h2aa), 1, 0);
    endtask

    task automatic t_fill_order();
        send("R5 same set new tag", 0, mk(3, 2, 11'h001), 0, 0);   // fills way 1
        send("R6 way1 hit", 0, mk(3, 2, 11'h7ff), 1, 1);
        send("R6 way0 hit", 0, mk(3, 5, 11'h123), 1, 0);
        send("R6 third fill", 0, mk(3, 7, 11'h0f0), 0, 0);        // evicts way0 (tag 5)
        send("R6 evicted tag", 0, mk(3, 5, 11'h00f), 0, 0);       // evicts way1 (tag 2)
        send("R6 new way0", 0, mk(3, 7, 11'h3c3), 1, 0);
        send("R6 new way1", 0, mk(3, 5, 11'h444), 1, 1);
        send("R6 tag2 gone", 0, mk(3, 2, 11'h555), 0, 0);         // evicts way0 (tag 7)
    endtask

    task automatic t_set15();
        send("R7 set15 cold", 1, mk(15, 1, 11'h111), 0, 0);
        send("R7 set15 hit", 1, mk(15, 1, 11'h222), 1, 0);
        send("R7 set15 second tag", 1, mk(15, 4, 11'h333), 0, 0);
        send("R7 set15 evicted", 1, mk(15, 1, 11'h444), 0, 0);
        send("R7 set15 rehit", 1, mk(15, 1, 11'h666), 1, 0);
        send("R7 set15 other evicted", 1, mk(15, 4, 11'h777), 0, 0);
    endtask

    task automatic t_banks();
        send("R8 bank2 cold", 2, mk(3, 5, 11'h0aa), 0, 0);
        send("R8 bank3 cold", 3, mk(3, 5, 11'h0bb), 0, 0);
        send("R8 bank0 undisturbed", 0, mk(3, 5, 11'h0cc), 1, 1);
        send("R8 bank2 hit", 2, mk(3, 5, 11'h0dd), 1, 0);
        send("R5 other set same tag", 2, mk(4, 5, 11'h0ee), 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cold_then_hit();
        t_fill_order();
        t_set15();
        t_banks();
        @(negedge clk);
        chk("R9 final idle", 32'(beat_valid), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule